// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave-only two-wire serial port. An external master uses it to read and write a byte-addressed register space. The block samples the SCL and SDA pad inputs on a fast system clock and drives a single pull-down enable for the open-drain SDA pad. It finds bus conditions, compares the device address, and takes a command byte that loads an internal register pointer. After that it carries out byte or continuous writes, and byte or continuous reads once a repeated START has turned the bus around.

The storage behind the block is reached through a plain register port with no back-pressure. A write is a one-cycle strobe that carries an address and a data byte. A read is a one-cycle strobe, and the storage must present the addressed byte on `reg_rd_data` during the next clock cycle. A `busy` input, driven by whatever is reloading or committing the storage, makes the block refuse new command bytes. The system clock must run at least 16 times the SCL rate.

Top module: `smb_regport_slave`

## Requirements
- R1: After reset, `sda_pull` is low and neither `reg_wr_en` nor `reg_rd_en` is asserted. SCL and SDA pass through two synchronizer flops. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.
- R2: The first byte after a START is the address. The block accepts it when bits 7..3 equal 10100b and bit 2 equals `addr_pin`, whatever bit 1 is. Bit 0 gives the direction: 1 means read. Any other address gets no ACK, and the rest of the frame is ignored until the next START or STOP.
- R3: For every address, command or write-data byte it accepts, the block pulls SDA low for the whole 9th clock. `sda_pull` is only ever raised while SCL is low.
- R4: A command byte is ACKed and loaded into the register pointer when it lies in 00h-17h, 18h-2Ah, 40h-7Fh or 80h-97h. Any other value is NACKed.
- R5: If `busy` is high when the command byte completes, that byte is NACKed.
- R6: Each data byte written to an address in 00h-17h, 40h-7Fh or 80h-97h is ACKed. It gives exactly one `reg_wr_en` cycle with the pointer on `reg_addr` and the byte on `reg_wr_data`. The pointer then increments, so continuous writes fill consecutive addresses.
- R7: Data bytes aimed at 18h-2Ah, or at a pointer outside every legal range, are ACKed but produce no write strobe.
- R8: A read frame sends the byte at the pointer, MSB first, and increments the pointer. A master ACK makes the block send the next byte. A master NACK ends the transfer and SDA stays released.
- R9: A read from a pointer outside every legal range returns FFh.
- R10: A STOP at any bit position ends the frame and releases SDA, and a partially received data byte is not written.
- R11: A STOP within the same SCL-high period as the START before it is ignored, and the frame continues with the address byte.
- R12: A repeated START followed by a write address starts a fresh write frame with its own command byte. Writes on both sides of the repeated START take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_pull | output | 1 | 1 pulls the SDA pad low |
| addr_pin | input | 1 | Strapped device address bit (address bit 2) |
| busy | input | 1 | Storage busy; new command bytes are NACKed |
| reg_addr | output | 8 | Register address for a write or read strobe |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data, valid the cycle after `reg_rd_en` |

## Verification
Single write-then-readback frames are run at the two ends of each legal range, inside the read-only range, and just past the ranges. These separate stored, discarded and refused bytes. Multi-byte writes and reads that cross from writable into read-only space, or from legal into illegal space, show that the pointer advances by exactly one per byte and that the read-only and FFh rules are applied to each byte on its own. The address byte is tried with the strap bit wrong, the don't-care bit set, and with START and STOP in the same high phase. Aborted and turned-around frames (a STOP in mid-byte, a repeated START between writes, a master NACK) check that state is dropped or kept exactly at the frame boundary.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } frame_st_t;

  localparam int          AW          = 8;
  localparam int          DW          = 8;
  localparam logic [4:0]  DEV_PREFIX  = 5'b10100;
  localparam int          N_RANGE     = 4;
  // range 0: config, 1: measurement (read-only), 2: user copy, 3: config copy
  localparam logic [N_RANGE*AW-1:0] RANGE_LO = {8'h80, 8'h40, 8'h18, 8'h00};
  localparam logic [N_RANGE*AW-1:0] RANGE_HI = {8'h97, 8'h7F, 8'h2A, 8'h17};
  localparam logic [N_RANGE-1:0]    RANGE_WR = 4'b1101;
  localparam logic [DW-1:0]         FILL_BYTE = 8'hFF;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_map_check.sv
module smb_map_check
  import smb_pkg::*;
#(
  parameter int                      NR = N_RANGE,
  parameter logic [NR*AW-1:0]        LO = RANGE_LO,
  parameter logic [NR*AW-1:0]        HI = RANGE_HI,
  parameter logic [NR-1:0]           WR = RANGE_WR
) (
  input  logic [AW-1:0] addr,
  output logic          legal,
  output logic          writable
);
  logic [NR-1:0] hit;

  for (genvar g = 0; g < NR; g++) begin : g_rng
    localparam logic [AW-1:0] L    = LO[g*AW +: AW];
    localparam logic [AW-1:0] SPAN = HI[g*AW +: AW] - LO[g*AW +: AW];
    logic [AW:0] diff;
    assign diff   = {1'b0, addr} - {1'b0, L};
    assign hit[g] = ~diff[AW] & (diff[AW-1:0] <= SPAN);
  end

  assign legal    = |hit;
  assign writable = |(hit & WR);

endmodule

// File: rtl/smb_frame_fsm.sv
module smb_frame_fsm
  import smb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_pin,
  input  logic          busy,
  input  logic          chk_legal,
  input  logic          chk_writable,
  output logic [AW-1:0] chk_addr,
  output logic          sda_pull,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wr_data,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rd_data
);
  frame_st_t       state, nxt;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, tx;
  logic [AW-1:0]   ptr;
  logic            start_hi, rd_legal;
  logic [1:0]      rd_pend;
  logic            addr_match, do_read;

  assign chk_addr   = (state == ST_CMD) ? shreg : ptr;
  assign addr_match = (shreg[7:3] == DEV_PREFIX) && (shreg[2] == addr_pin);

  // fetch on the 9th rising edge: after address (read) or on master ACK
  assign do_read = scl_rise && (bitcnt == 4'd8) &&
                   (((state == ST_ADDR) && (nxt == ST_RDATA)) ||
                    ((state == ST_RDATA) && !sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      nxt         <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      tx          <= '0;
      ptr         <= '0;
      start_hi    <= 1'b0;
      rd_legal    <= 1'b0;
      rd_pend     <= '0;
      sda_pull    <= 1'b0;
      reg_addr    <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      reg_rd_en   <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      rd_pend   <= {rd_pend[0], 1'b0};
      if (rd_pend[1]) tx <= rd_legal ? reg_rd_data : FILL_BYTE;

      if (stop_det && !start_hi) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        nxt      <= ST_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        start_hi <= 1'b1;
      end else begin
        if (!scl_s) start_hi <= 1'b0;

        if (do_read) begin
          reg_addr   <= ptr;
          reg_rd_en  <= 1'b1;
          rd_legal   <= chk_legal;
          rd_pend[0] <= 1'b1;
          ptr        <= ptr + 8'd1;
        end

        if (scl_rise && state != ST_IDLE && state != ST_SKIP) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (state == ST_RDATA && sda_s) nxt <= ST_SKIP;
          end
        end

        if (scl_fall && state != ST_IDLE && state != ST_SKIP) begin
          if (bitcnt == 4'd8) begin
            case (state)
              ST_ADDR: begin
                if (addr_match) begin
                  sda_pull <= 1'b1;
                  nxt      <= shreg[0] ? ST_RDATA : ST_CMD;
                end else begin
                  nxt      <= ST_SKIP;
                end
              end
              ST_CMD: begin
                if (chk_legal && !busy) begin
                  sda_pull <= 1'b1;
                  ptr      <= shreg;
                  nxt      <= ST_WDATA;
                end else begin
                  nxt      <= ST_SKIP;
                end
              end
              ST_WDATA: begin
                sda_pull <= 1'b1;
                nxt      <= ST_WDATA;
                if (chk_writable) begin
                  reg_wr_en   <= 1'b1;
                  reg_addr    <= ptr;
                  reg_wr_data <= shreg;
                end
                ptr <= ptr + 8'd1;
              end
              ST_RDATA: begin
                sda_pull <= 1'b0;
                nxt      <= ST_RDATA;
              end
              default: nxt <= ST_SKIP;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt   <= '0;
            state    <= nxt;
            sda_pull <= (nxt == ST_RDATA) ? ~tx[7] : 1'b0;
          end else if (state == ST_RDATA && bitcnt != 4'd0) begin
            sda_pull <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end

endmodule

// File: rtl/smb_regport_slave.sv
module smb_regport_slave
  import smb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  input  logic          addr_pin,
  input  logic          busy,
  output logic [7:0]    reg_addr,
  output logic          reg_wr_en,
  output logic [7:0]    reg_wr_data,
  output logic          reg_rd_en,
  input  logic [7:0]    reg_rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] chk_addr;
  logic chk_legal, chk_writable;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_map_check u_map (
    .addr(chk_addr), .legal(chk_legal), .writable(chk_writable)
  );

  smb_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_pin(addr_pin), .busy(busy),
    .chk_legal(chk_legal), .chk_writable(chk_writable), .chk_addr(chk_addr),
    .sda_pull(sda_pull), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

endmodule

// File: rtl/smb_slave_chk.sv
module smb_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_pull,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic [7:0] reg_addr
);
  logic wr_ok;
  assign wr_ok = (reg_addr <= 8'h17) ||
                 (reg_addr >= 8'h40 && reg_addr <= 8'h97);

  // R3: pull-down only starts while SCL is low
  a_r3_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_s));

  // R10: SDA is free in the cycle after a STOP
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // R6: one write strobe per byte
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R7: no write strobe outside writable space
  a_r7_writable_only: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> wr_ok);

  // R8: reads and writes never overlap, read strobe lasts one cycle
  a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));
  a_r8_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

endmodule

bind smb_regport_slave smb_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_pull(sda_pull), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr)
);

// File: tb/sim_smb_regport_slave.sv
`timescale 1ns/1ps
module sim_smb_regport_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NV         = 10;
  localparam logic [7:0] AW_W = 8'hA4;
  localparam logic [7:0] AW_R = 8'hA5;
  // {cmd, data, cmd_ack, readback}
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 8'h3C, 1'b1, 8'h3C},
    {8'h17, 8'hA5, 1'b1, 8'hA5},
    {8'h18, 8'h77, 1'b1, 8'h5A},
    {8'h2A, 8'h11, 1'b1, 8'hC3},
    {8'h40, 8'h0F, 1'b1, 8'h0F},
    {8'h7F, 8'hF0, 1'b1, 8'hF0},
    {8'h80, 8'h81, 1'b1, 8'h81},
    {8'h97, 8'h69, 1'b1, 8'h69},
    {8'h30, 8'h55, 1'b0, 8'h00},
    {8'h98, 8'h12, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_pin = 1'b1, busy = 1'b0;
  logic sda_pull, reg_wr_en, reg_rd_en;
  logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
  logic sda_line;
  logic [7:0] mem [256];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  smb_regport_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .addr_pin(addr_pin), .busy(busy),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      mem[8'h18] <= 8'h5A;
      mem[8'h2A] <= 8'hC3;
      reg_rd_data <= 8'h00;
    end else begin
      if (reg_wr_en) mem[reg_addr] <= reg_wr_data;
      if (reg_rd_en) reg_rd_data <= mem[reg_addr];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    end
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
    ack = ~sda_line; tick(Q/2); scl_m = 1'b0;
  endtask

  task automatic rb(output logic [7:0] d, input logic m_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q/2); d[i] = sda_line; tick(Q/2); scl_m = 1'b0;
    end
    sda_m = m_ack ? 1'b0 : 1'b1; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic read_at(input logic [7:0] a, input int n, output logic [23:0] d);
    logic ack;
    logic [7:0] b;
    d = '0;
    bus_start(); wb(AW_W, ack); wb(a, ack);
    bus_start(); wb(AW_R, ack);
    for (int k = 0; k < n; k++) begin
      rb(b, k != n - 1);
      d = {d[15:0], b};
    end
    bus_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [23:0] d;
    tick(5);
    // R1 reset state
    chk(sda_pull == 1'b0 && reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 reset",
        {sda_pull, reg_wr_en, reg_rd_en}, 0);
    rst_n = 1'b1;
    tick(5);

    // table walk: R4 range check, R6/R7 write and readback
    for (int v = 0; v < NV; v++) begin
      bus_start(); wb(AW_W, ack);
      chk(ack, "R2 addr ack", ack, 1);
      wb(VEC[v][24:17], ack);
      chk(ack == VEC[v][8], "R4 cmd ack", ack, VEC[v][8]);
      if (VEC[v][8]) begin
        wb(VEC[v][16:9], ack);
        chk(ack, "R6/R7 data ack", ack, 1);
      end
      bus_stop();
      if (VEC[v][8]) begin
        read_at(VEC[v][24:17], 1, d);
        chk(d[7:0] == VEC[v][7:0], "R6/R7 readback", d[7:0], VEC[v][7:0]);
      end
    end

    // R2 strap mismatch and prefix mismatch
    bus_start(); wb(8'hA0, ack); bus_stop();
    chk(!ack, "R2 strap mismatch", ack, 0);
    bus_start(); wb(8'hB4, ack); bus_stop();
    chk(!ack, "R2 prefix mismatch", ack, 0);
    // R2 don't-care bit set
    bus_start(); wb(8'hA6, ack); bus_stop();
    chk(ack, "R2 dont-care bit", ack, 1);

    // R5 busy
    busy = 1'b1;
    bus_start(); wb(AW_W, ack); wb(8'h05, ack); bus_stop();
    chk(!ack, "R5 busy cmd nack", ack, 0);
    busy = 1'b0;

    // R6/R7 continuous write across 17h->18h, R3 release after ack
    bus_start(); wb(AW_W, ack); wb(8'h16, ack);
    wb(8'h11, ack); wb(8'h22, ack); wb(8'h33, ack);
    chk(ack, "R7 ro data acked", ack, 1);
    tick(6);
    chk(sda_pull == 1'b0, "R3 release after ack", sda_pull, 0);
    bus_stop();
    // R8 continuous read
    read_at(8'h16, 3, d);
    chk(d == 24'h11225A, "R8 continuous read", d, 24'h11225A);
    chk(sda_pull == 1'b0, "R8 release after nack", sda_pull, 0);

    // R9 read past legal space
    read_at(8'h2A, 2, d);
    chk(d[15:0] == 16'hC3FF, "R9 illegal read FFh", d[15:0], 16'hC3FF);

    // R10 STOP mid-byte
    bus_start(); wb(AW_W, ack); wb(8'h05, ack); send_bits(8'hAA, 4); bus_stop();
    chk(sda_pull == 1'b0, "R10 released", sda_pull, 0);
    read_at(8'h05, 1, d);
    chk(d[7:0] == 8'h00, "R10 partial byte dropped", d[7:0], 0);

    // R11 START and STOP in same high phase
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q); scl_m = 1'b0;
    wb(AW_W, ack); bus_stop();
    chk(ack, "R11 stop ignored", ack, 1);

    // R12 repeated START between writes
    bus_start(); wb(AW_W, ack); wb(8'h01, ack); wb(8'h21, ack);
    bus_start(); wb(AW_W, ack); wb(8'h02, ack); wb(8'h42, ack); bus_stop();
    read_at(8'h01, 2, d);
    chk(d[15:0] == 16'h2142, "R12 writes around SR", d[15:0], 16'h2142);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule